// File: doc/BRIEF.md
# Infrared Raw Symbol Capture Controller

This block watches the demodulated output of an infrared receiver and turns the waveform into a list of timed symbols. A symbol starts when the line falls. Its low interval runs until the line rises again, and its high interval runs until the line falls once more. Both intervals are counted in units of ten microseconds. A prescaler, programmed with the clock frequency, produces those units. Each finished symbol is packed into one 32-bit word and pushed into a receive FIFO. Software drains the FIFO through a small register port.

A stream of symbols ends when the high interval grows too long. When the low part plus the high part reaches a programmable maximum width, the block stores the symbol with its high part cut to that maximum and flags a timeout. It then stays idle until the next falling edge. Three interrupt sources are provided: a FIFO level threshold, the end-of-stream timeout, and overflow. On overflow the newest symbol is dropped and the stored ones are kept for software to read.

The register port uses synchronous read and write strobes with a word index. A read returns its data within the same cycle, and a read of the data register pops the FIFO on the clock edge that ends that cycle.

Top module: `ir_symbol_capture`

## Requirements
- R1: Each FIFO word holds the low duration in bits 15:0 and the high duration in bits 31:16. The low interval is measured from a falling edge to the next rising edge, and the high interval from that rising edge to the next falling edge, which also starts the next symbol.
- R2: The frequency field is configuration bits 6:0 and holds F. Together with the ÷10 stage it sets one duration unit to 10·(F+1) clocks. The unit timebase restarts on every input edge, so an interval of N clocks counts floor((N−1)/(10·(F+1))).
- R3: Let lo be the symbol's low part and MAX the maximum width in configuration bits 31:16. When lo plus the growing high count reaches MAX, the symbol is stored with high = MAX − lo. Timeout status then sets, in bit 9 with a mirror in bit 25. Nothing more is stored until a falling edge starts a new symbol.
- R4: A read of register 4 returns the number of stored symbols. A read of register 5 returns the oldest word and pops it. When the FIFO is empty, register 5 reads 0 and the count is left unchanged.
- R5: The level field is configuration bits 13:8 and holds L. Symbol-received status, in bit 8 with a mirror in bit 24, sets once the count reaches L+1 and stays set until it is cleared.
- R6: A symbol that completes while the FIFO holds DEPTH (64) words is dropped. Overflow status then sets, in bit 10 with a mirror in bit 26, and the stored words are kept in their order.
- R7: Status is register 7, and register 8 clears it. Writing 1 to bits 16, 17 and 18 of register 8 clears received, timeout and overflow respectively. A write whose low byte is 0xFF clears every flag.
- R8: Mask is register 6, with bits 8, 9 and 10 masking received, timeout and overflow. The mask resets to all ones. irq_o is high exactly when some status flag is set and its mask bit is 0.
- R9: A write to register 0 with bit 0 set enables the block. Busy (register 2, bit 0) then reads 1 from the next cycle for INIT_CYCLES cycles. A write of any value to register 3 arms the capture only while the block is enabled and not busy. No symbol is stored while the capture is not armed.
- R10: After reset, configuration (register 1) reads 0x3E800080: the maximum width is 0x3E80, the level is 0, raw mode is bit 7, and the frequency field is 0. Count, status, busy and irq_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ir_i | input | 1 | Demodulated receiver line (idle high) |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | ADDR_W | Register word index |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid in the strobe cycle |
| irq_o | output | 1 | Interrupt request |

## Verification
An input edge passes two synchronizer flops, so the meter sees it on the third clock edge after the change. A symbol closed by a falling edge is therefore counted in the FIFO by that edge. The bench changes ir_i and every strobe on falling clock edges. It reads the FIFO count no sooner than five cycles after the closing edge. It samples read data half a cycle after the strobe is raised, before the popping edge. Busy is sampled in the cycle right after the enable write and again after INIT_CYCLES plus a margin. The timeout word is checked only after the third unit tick of the high phase has certainly passed. Interval lengths are chosen as whole units plus half a unit, so that the expected counts do not depend on where an edge falls within a unit.

// File: rtl/ir_cap_pkg.sv
`timescale 1ns/1ps
package ir_cap_pkg;
  localparam int DUR_W  = 16;
  localparam int WORD_W = 2 * DUR_W;

  typedef enum logic [1:0] {ST_IDLE, ST_LOW, ST_HIGH} meter_st_e;

  // field order matches the configuration word bit positions
  typedef struct packed {
    logic [15:0] max_w;
    logic [1:0]  fmt;
    logic [5:0]  lvl;
    logic        raw;
    logic [6:0]  freq;
  } cfg_t;

  localparam logic [31:0] CFG_RST = 32'h3E80_0080;

  localparam int REG_EN     = 0;
  localparam int REG_CFG    = 1;
  localparam int REG_BUSY   = 2;
  localparam int REG_START  = 3;
  localparam int REG_COUNT  = 4;
  localparam int REG_DATA   = 5;
  localparam int REG_MASK   = 6;
  localparam int REG_STATUS = 7;
  localparam int REG_CLEAR  = 8;
endpackage

// File: rtl/ir_prescaler.sv
`timescale 1ns/1ps
module ir_prescaler #(
  parameter int FREQ_W = 7,
  parameter int DIV    = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              clr_i,
  input  logic [FREQ_W-1:0] freq_i,
  output logic              unit_tick_o
);
  localparam int DEC_W = $clog2(DIV);

  logic [FREQ_W-1:0] us_q;
  logic [DEC_W-1:0]  dec_q;
  logic              us_tick;

  assign us_tick     = run_i && !clr_i && (us_q == freq_i);
  assign unit_tick_o = us_tick && (dec_q == DEC_W'(DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      us_q  <= '0;
      dec_q <= '0;
    end else if (!run_i || clr_i) begin
      us_q  <= '0;
      dec_q <= '0;
    end else begin
      us_q <= us_tick ? '0 : us_q + 1'b1;
      if (us_tick) dec_q <= (dec_q == DEC_W'(DIV - 1)) ? '0 : dec_q + 1'b1;
    end
  end
endmodule

// File: rtl/ir_symbol_meter.sv
`timescale 1ns/1ps
module ir_symbol_meter
  import ir_cap_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ir_i,
  input  logic          armed_i,
  input  logic          unit_tick_i,
  input  logic [DW-1:0] max_w_i,
  output logic          edge_o,
  output logic          push_o,
  output logic          tmo_o,
  output logic [2*DW-1:0] word_o
);
  logic [2:0]    s_q;
  logic          fall, rise;
  meter_st_e     st_q;
  logic [DW-1:0] lo_q, hi_q, nxt_hi, hi_sat;
  logic [DW:0]   sum;
  logic          hit_max;

  assign fall   = s_q[2] & ~s_q[1];
  assign rise   = ~s_q[2] & s_q[1];
  assign edge_o = fall | rise;

  always_comb begin
    nxt_hi  = hi_q + 1'b1;
    sum     = {1'b0, lo_q} + {1'b0, nxt_hi};
    hit_max = sum >= {1'b0, max_w_i};
    hi_sat  = (lo_q >= max_w_i) ? '0 : max_w_i - lo_q;
    push_o  = 1'b0;
    tmo_o   = 1'b0;
    word_o  = {hi_q, lo_q};
    if (armed_i && st_q == ST_HIGH) begin
      if (fall) begin
        push_o = 1'b1;
      end else if (unit_tick_i && hit_max) begin
        push_o = 1'b1;
        tmo_o  = 1'b1;
        word_o = {hi_sat, lo_q};
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s_q  <= 3'b111;
      st_q <= ST_IDLE;
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      s_q <= {s_q[1:0], ir_i};
      if (!armed_i) begin
        st_q <= ST_IDLE;
      end else begin
        case (st_q)
          ST_IDLE: if (fall) begin st_q <= ST_LOW; lo_q <= '0; end
          ST_LOW: begin
            if (rise) begin
              st_q <= ST_HIGH;
              hi_q <= '0;
            end else if (unit_tick_i && lo_q != '1) begin
              lo_q <= lo_q + 1'b1;
            end
          end
          ST_HIGH: begin
            if (fall) begin
              st_q <= ST_LOW;
              lo_q <= '0;
            end else if (unit_tick_i) begin
              if (hit_max) st_q <= ST_IDLE;
              else         hi_q <= nxt_hi;
            end
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  assert_no_store_disarmed_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_i |-> !push_o);
  assert_tmo_sum_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_o |-> (lo_q >= max_w_i) ||
              ({1'b0, word_o[DW-1:0]} + {1'b0, word_o[2*DW-1:DW]} == {1'b0, max_w_i}));
  assert_idle_after_tmo_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_o |=> st_q == ST_IDLE);
endmodule

// File: rtl/ir_sym_fifo.sv
`timescale 1ns/1ps
module ir_sym_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 64
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           push_i,
  input  logic [WIDTH-1:0]               wdata_i,
  input  logic                           pop_i,
  output logic [WIDTH-1:0]               rdata_o,
  output logic [$clog2(DEPTH+1)-1:0]     count_o,
  output logic                           full_o,
  output logic                           empty_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp_q, rp_q;
  logic [CW-1:0]    cnt_q;
  logic             wr_ok, rd_ok;

  assign full_o  = cnt_q == CW'(DEPTH);
  assign empty_o = cnt_q == '0;
  assign wr_ok   = push_i && !full_o;
  assign rd_ok   = pop_i && !empty_o;
  assign rdata_o = mem[rp_q];
  assign count_o = cnt_q;

  always_ff @(posedge clk_i) begin
    if (wr_ok) mem[wp_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (wr_ok) wp_q <= (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
      if (rd_ok) rp_q <= (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      cnt_q <= cnt_q + CW'(wr_ok) - CW'(rd_ok);
    end
  end

  assert_count_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  assert_empty_pop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty_o && !push_i) |=> empty_o);
endmodule

// File: rtl/ir_symbol_capture.sv
`timescale 1ns/1ps
module ir_symbol_capture
  import ir_cap_pkg::*;
#(
  parameter int DEPTH       = 64,
  parameter int INIT_CYCLES = 16,
  parameter int ADDR_W      = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ir_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              irq_o
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int BW = $clog2(INIT_CYCLES + 1);

  cfg_t          cfg_q;
  logic          en_q, armed_q;
  logic [BW-1:0] busy_q;
  logic [2:0]    mask_q, st_q, st_set, st_clr;
  logic          wr_en, wr_start, wr_clr, pop;
  logic          m_edge, m_push, m_tmo, unit_tick;
  logic [WORD_W-1:0] m_word, f_rdata;
  logic [CW-1:0] f_count;
  logic          f_full, f_empty;

  assign wr_en    = reg_wr_i && reg_addr_i == ADDR_W'(REG_EN);
  assign wr_start = reg_wr_i && reg_addr_i == ADDR_W'(REG_START);
  assign wr_clr   = reg_wr_i && reg_addr_i == ADDR_W'(REG_CLEAR);
  assign pop      = reg_rd_i && reg_addr_i == ADDR_W'(REG_DATA);

  ir_prescaler #(.FREQ_W(7), .DIV(10)) u_presc (
    .clk_i, .rst_ni, .run_i(armed_q), .clr_i(m_edge),
    .freq_i(cfg_q.freq), .unit_tick_o(unit_tick));

  ir_symbol_meter #(.DW(DUR_W)) u_meter (
    .clk_i, .rst_ni, .ir_i, .armed_i(armed_q), .unit_tick_i(unit_tick),
    .max_w_i(cfg_q.max_w), .edge_o(m_edge), .push_o(m_push),
    .tmo_o(m_tmo), .word_o(m_word));

  ir_sym_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni, .push_i(m_push), .wdata_i(m_word), .pop_i(pop),
    .rdata_o(f_rdata), .count_o(f_count), .full_o(f_full), .empty_o(f_empty));

  always_comb begin
    st_set[0] = int'(f_count) >= int'(cfg_q.lvl) + 1;
    st_set[1] = m_tmo;
    st_set[2] = m_push && f_full;
    st_clr    = '0;
    if (wr_clr) st_clr = (reg_wdata_i[7:0] == 8'hFF) ? 3'b111 : reg_wdata_i[18:16];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q   <= cfg_t'(CFG_RST);
      en_q    <= 1'b0;
      armed_q <= 1'b0;
      busy_q  <= '0;
      mask_q  <= 3'b111;
      st_q    <= '0;
    end else begin
      if (wr_en) begin
        en_q    <= reg_wdata_i[0];
        busy_q  <= reg_wdata_i[0] ? BW'(INIT_CYCLES) : '0;
        armed_q <= 1'b0;
      end else begin
        if (busy_q != '0) busy_q <= busy_q - 1'b1;
        if (wr_start && en_q && busy_q == '0) armed_q <= 1'b1;
      end
      if (reg_wr_i && reg_addr_i == ADDR_W'(REG_CFG))  cfg_q  <= cfg_t'(reg_wdata_i);
      if (reg_wr_i && reg_addr_i == ADDR_W'(REG_MASK)) mask_q <= reg_wdata_i[10:8];
      st_q <= (st_q & ~st_clr) | st_set;
    end
  end

  assign irq_o = |(st_q & ~mask_q);

  always_comb begin
    reg_rdata_o = '0;
    case (int'(reg_addr_i))
      REG_EN:     reg_rdata_o = {31'b0, en_q};
      REG_CFG:    reg_rdata_o = cfg_q;
      REG_BUSY:   reg_rdata_o = {31'b0, busy_q != '0};
      REG_COUNT:  reg_rdata_o = 32'(f_count);
      REG_DATA:   reg_rdata_o = f_empty ? '0 : f_rdata;
      REG_MASK:   reg_rdata_o = {21'b0, mask_q, 8'b0};
      REG_STATUS: reg_rdata_o = {5'b0, st_q, 13'b0, st_q, 8'b0};
      default:    reg_rdata_o = '0;
    endcase
  end

  assert_busy_on_enable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && reg_wdata_i[0]) |=> busy_q != '0);
  assert_ovf_flag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_push && f_full) |=> st_q[2]);
  assert_tmo_flag_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_tmo |=> st_q[1]);
  assert_masked_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == 3'b111) |-> !irq_o);
endmodule

// File: tb/tb_ir_symbol_capture.sv
`timescale 1ns/1ps
module tb_ir_symbol_capture;
  localparam int INIT = 16;
  localparam int UNIT = 10;
  localparam int A_EN = 0, A_CFG = 1, A_BUSY = 2, A_START = 3, A_CNT = 4,
                 A_DATA = 5, A_MASK = 6, A_ST = 7, A_CLR = 8;

  logic clk = 1'b0, rst_n = 1'b0, ir = 1'b1;
  logic wr = 1'b0, rd = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        irq;
  int checks = 0, errors = 0;
  logic [31:0] v;

  always #2.5 clk = ~clk;

  ir_symbol_capture #(.DEPTH(64), .INIT_CYCLES(INIT), .ADDR_W(4)) dut (
    .clk_i(clk), .rst_ni(rst_n), .ir_i(ir), .reg_wr_i(wr), .reg_rd_i(rd),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // all tasks start and end on a falling clock edge
  task automatic reg_write(input int a, input logic [31:0] d);
    wr = 1'b1; addr = 4'(a); wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic reg_read(input int a, output logic [31:0] d);
    rd = 1'b1; addr = 4'(a);
    #1 d = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic ir_phase(input logic val, input int n);
    ir = val;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_symbol(input int a, input int b, input int unit);
    ir_phase(1'b0, unit * a + unit / 2);
    ir_phase(1'b1, unit * b + unit / 2);
  endtask

  task automatic restart(input logic [31:0] cfg);
    reg_write(A_EN, 0);
    ir_phase(1'b1, 4);
    reg_write(A_CFG, cfg);
    reg_write(A_EN, 1);
    reg_write(A_START, 1);
    repeat (INIT + 2) @(negedge clk);
    reg_write(A_START, 1);
  endtask

  function automatic logic [31:0] mkcfg(input int maxw, input int lvl, input int freq);
    return {16'(maxw), 2'b00, 6'(lvl), 1'b1, 7'(freq)};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    reg_read(A_CFG, v);  chk("R10 cfg reset", v, 32'h3E80_0080);
    reg_read(A_CNT, v);  chk("R10 count reset", v, 0);
    reg_read(A_ST, v);   chk("R10 status reset", v, 0);
    reg_read(A_BUSY, v); chk("R10 busy reset", v, 0);
    chk("R10 irq reset", 32'(irq), 0);
    reg_read(A_MASK, v); chk("R8 mask reset all ones", v, 32'h0000_0700);

    // R9 start while disabled is ignored
    reg_write(A_START, 1);
    send_symbol(1, 1, UNIT); ir_phase(1'b0, 8); ir_phase(1'b1, 8);
    reg_read(A_CNT, v); chk("R9 no capture when disabled", v, 0);

    // R9 busy window; start during busy ignored
    reg_write(A_EN, 1);
    reg_read(A_BUSY, v); chk("R9 busy after enable", v, 1);
    reg_write(A_START, 1);
    send_symbol(1, 1, UNIT); ir_phase(1'b0, 8); ir_phase(1'b1, 8);
    reg_read(A_BUSY, v); chk("R9 busy ends", v, 0);
    reg_read(A_CNT, v);  chk("R9 start during busy ignored", v, 0);

    // R1 R2 R5 sweep with level 15
    restart(mkcfg(1000, 15, 0));
    for (int i = 0; i < 16; i++) send_symbol(i % 4, i / 4, UNIT);
    reg_read(A_ST, v); chk("R5 below level", v & 32'h0100_0100, 0);
    ir_phase(1'b0, 8);
    reg_read(A_CNT, v); chk("R4 count after sweep", v, 16);
    reg_read(A_ST, v);  chk("R5 level reached", v, 32'h0100_0100);
    for (int i = 0; i < 16; i++) begin
      reg_read(A_DATA, v);
      chk("R1 R2 sweep word", v, {16'(i / 4), 16'(i % 4)});
    end
    reg_read(A_CNT, v);  chk("R4 drained", v, 0);
    reg_read(A_DATA, v); chk("R4 empty read zero", v, 0);
    reg_read(A_CNT, v);  chk("R4 empty pop keeps count", v, 0);
    reg_read(A_ST, v);   chk("R5 sticky", v, 32'h0100_0100);
    reg_write(A_CLR, 32'h0001_0000);
    reg_read(A_ST, v);   chk("R7 clear received", v, 0);

    // R2 frequency field = 1, unit of 20 clocks
    restart(mkcfg(1000, 0, 1));
    send_symbol(2, 3, 2 * UNIT); send_symbol(1, 0, 2 * UNIT); ir_phase(1'b0, 8);
    reg_read(A_CNT, v);  chk("R2 freq1 count", v, 2);
    reg_read(A_DATA, v); chk("R2 freq1 word0", v, 32'h0003_0002);
    reg_read(A_DATA, v); chk("R2 freq1 word1", v, 32'h0000_0001);
    reg_write(A_CLR, 32'hFF);

    // R3 timeout with max width 5
    restart(mkcfg(5, 0, 0));
    ir_phase(1'b0, 25); ir_phase(1'b1, 60);
    reg_read(A_CNT, v); chk("R3 timeout stored", v, 1);
    reg_read(A_ST, v);  chk("R3 timeout status", v, 32'h0300_0300);
    ir_phase(1'b1, 100);
    reg_read(A_CNT, v);  chk("R3 idle after timeout", v, 1);
    reg_read(A_DATA, v); chk("R3 saturated high", v, 32'h0003_0002);
    send_symbol(1, 1, UNIT); ir_phase(1'b0, 8);
    reg_read(A_DATA, v); chk("R3 resumes on fall", v, 32'h0001_0001);

    // R8 masking, R7 single clear
    chk("R8 masked no irq", 32'(irq), 0);
    reg_write(A_MASK, 32'h0000_0500);
    chk("R8 unmasked timeout irq", 32'(irq), 1);
    reg_write(A_CLR, 32'h0002_0000);
    chk("R7 R8 irq after timeout clear", 32'(irq), 0);
    reg_read(A_ST, v); chk("R7 only timeout cleared", v, 32'h0100_0100);

    // R6 overflow with level 63
    restart(mkcfg(1000, 63, 0));
    reg_write(A_CLR, 32'hFF);
    reg_write(A_MASK, 32'h0);
    for (int i = 0; i < 65; i++) send_symbol(i % 4, (i / 4) % 4, UNIT);
    reg_read(A_ST, v); chk("R6 full no overflow yet", v, 32'h0100_0100);
    ir_phase(1'b0, 8);
    reg_read(A_CNT, v); chk("R6 count stays full", v, 64);
    reg_read(A_ST, v);  chk("R6 overflow status", v, 32'h0500_0500);
    chk("R8 irq on overflow", 32'(irq), 1);
    for (int i = 0; i < 64; i++) begin
      reg_read(A_DATA, v);
      chk("R6 contents intact", v, {16'((i / 4) % 4), 16'(i % 4)});
    end
    reg_write(A_CLR, 32'h0000_00FF);
    reg_read(A_ST, v); chk("R7 clear all", v, 0);
    chk("R7 irq after clear all", 32'(irq), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule